// File: doc/BRIEF.md
# CAMAC Crate Command Register Interface

This block connects a host asynchronous memory bus to the sequencer that runs CAMAC dataway cycles. The host makes 32-bit, word-aligned accesses. Address bits 15..12 pick one of sixteen internal words. Writes to the cycle word are split between the two halves of the access. The address carries the station number, the top function bit and a launch flag. The data word carries the low function bits, the subaddress and the 24 write lines.

When the launch flag is set and no cycle is outstanding, the block latches the fields and sends a one-cycle start pulse with N/F/A/W to the sequencer. It stays busy until the sequencer returns a done pulse. The done pulse carries read data, Q and X, and the block captures them into a status word.

A command word drives crate-control pulses, two control levels and a 16-bit LED bus. The register file also holds a scratch word and a fixed revision word for bus checks.

Top module: `crate_cmd_regs`

## Requirements
- R1: `host_rdata` is combinational, and it is zero while `host_rd` is low. The word selected by `host_addr[15:12]` behaves as follows:
  - Index 0 returns the `REVISION` parameter.
  - Index 1 (command) reads as zero.
  - Indices 3 and 7..15 read as zero.
- R2: Index 2 is a scratch word. It returns exactly the last 32-bit value written, and it is zero after reset.
- R3: A write to index 4 latches the data word and the address. The sequencer fields are N = addr[8:4], F = {addr[3], data[31:28]}, A = data[27:24] and W = data[23:0]. A read of index 4 returns the latched data. A read of index 5 returns the latched address in bits 15..0 and zero above them. Address bits 11..9 have no effect on N, F, A or W.
- R4: A write to index 4 with addr[2]=1 gives `seq_start` high for exactly the one cycle after the write edge, with the new fields already on `seq_n/seq_f/seq_a/seq_w`. With addr[2]=0 the fields are still latched, but no start pulse is produced.
- R5: The status word is read at index 6. Its bit 27 (busy) is 1 from the cycle of `seq_start` until the cycle after `seq_done`. Its bit 26 (done) clears when a cycle starts and sets in the cycle after `seq_done`.
- R6: On `seq_done`, the status word captures `seq_rdata` into bits 23..0, `seq_q` into bit 24 and `seq_x` into bit 25. Bit 28 always mirrors the `seq_busy_out` input. Bits 31..29 read as zero.
- R7: While busy, any write to index 4 is ignored. No start pulse is produced, and the fields and the read-back words keep their values.
- R8: A write to index 1 with code 7 in data[3:0] loads data[31:16] onto `led`. No other write changes `led`, which is zero after reset.
- R9: A write to index 1 with code 1, 2, 4 or 5 in data[3:0] pulses `ctl_reset`, `ctl_reconfig`, `ctl_zero` or `ctl_clear` respectively. The pulse lasts exactly one cycle after the write edge.
- R10: Code 3 sets the `test_mode` level to data[31]. Code 6 sets the `inhibit` level to data[31]. Both levels are zero after reset.
- R11: Writes to indices 0 and 6 have no effect on what those words read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | Host read enable |
| host_addr | input | 16 | Host word address (bits 15..12 select the register) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| seq_start | output | 1 | One-cycle launch pulse to the crate sequencer |
| seq_n | output | 5 | Station number |
| seq_f | output | 5 | Function code |
| seq_a | output | 4 | Subaddress |
| seq_w | output | 24 | Write lines |
| seq_done | input | 1 | Cycle finished pulse from the sequencer |
| seq_rdata | input | 24 | Read lines returned with done |
| seq_q | input | 1 | Q response returned with done |
| seq_x | input | 1 | X (command accepted) returned with done |
| seq_busy_out | input | 1 | Output-busy indication from the sequencer |
| ctl_reset | output | 1 | Reset command pulse |
| ctl_reconfig | output | 1 | Reconfigure command pulse |
| ctl_zero | output | 1 | Crate initialise (Z) pulse |
| ctl_clear | output | 1 | Crate clear (C) pulse |
| test_mode | output | 1 | Test-mode level |
| inhibit | output | 1 | Inhibit (I) level |
| led | output | 16 | Front-panel LED word |

## Verification
The hardest situation to reach from the ports is a launch attempt while a cycle is still outstanding. The rule that this write leaves fields and read-back untouched can only be seen while the sequencer is withholding its done pulse. The bench plays the sequencer itself: it starts a cycle, keeps `seq_done` low, and issues a second start with different fields. It then reads indices 4 and 5 and the sequencer outputs before it releases done with chosen R, Q and X values and checks the captured status.

// File: rtl/crate_pkg.sv
package crate_pkg;
    localparam int HOST_DW = 32;
    localparam int HOST_AW = 16;
    localparam int RD_W    = 24;
    localparam int LED_W   = 16;
    localparam int NREG    = 16;

    localparam logic [3:0] IDX_REV  = 4'd0;
    localparam logic [3:0] IDX_CMD  = 4'd1;
    localparam logic [3:0] IDX_SCR  = 4'd2;
    localparam logic [3:0] IDX_CYC  = 4'd4;
    localparam logic [3:0] IDX_ADR  = 4'd5;
    localparam logic [3:0] IDX_STAT = 4'd6;

    localparam logic [3:0] OP_RESET  = 4'd1;
    localparam logic [3:0] OP_RECONF = 4'd2;
    localparam logic [3:0] OP_TEST   = 4'd3;
    localparam logic [3:0] OP_ZERO   = 4'd4;
    localparam logic [3:0] OP_CLEAR  = 4'd5;
    localparam logic [3:0] OP_INHIB  = 4'd6;
    localparam logic [3:0] OP_LED    = 4'd7;

    typedef struct packed {
        logic [HOST_DW-1:0] data;
        logic [HOST_AW-1:0] addr;
        logic               start;
        logic               busy;
        logic               done;
        logic [RD_W-1:0]    rdat;
        logic               q;
        logic               x;
    } cyc_state_t;

    typedef struct packed {
        logic             p_reset;
        logic             p_reconf;
        logic             p_zero;
        logic             p_clear;
        logic             test;
        logic             inhib;
        logic [LED_W-1:0] led;
    } cmd_state_t;
endpackage

// File: rtl/crate_addr_decode.sv
module crate_addr_decode
    import crate_pkg::*;
(
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    output logic [3:0]         idx,
    output logic [NREG-1:0]    wr_sel
);
    assign idx = host_addr[HOST_AW-1 -: 4];

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign wr_sel[i] = host_wr && (idx == 4'(i));
    end
endmodule

// File: rtl/crate_cmd_unit.sv
module crate_cmd_unit
    import crate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       code,
    input  logic [LED_W-1:0] arg,
    output logic             ctl_reset,
    output logic             ctl_reconfig,
    output logic             ctl_zero,
    output logic             ctl_clear,
    output logic             test_mode,
    output logic             inhibit,
    output logic [LED_W-1:0] led
);
    cmd_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.p_reset  = 1'b0;
        st_d.p_reconf = 1'b0;
        st_d.p_zero   = 1'b0;
        st_d.p_clear  = 1'b0;
        if (wr_en) begin
            case (code)
                OP_RESET:  st_d.p_reset  = 1'b1;
                OP_RECONF: st_d.p_reconf = 1'b1;
                OP_TEST:   st_d.test     = arg[LED_W-1];
                OP_ZERO:   st_d.p_zero   = 1'b1;
                OP_CLEAR:  st_d.p_clear  = 1'b1;
                OP_INHIB:  st_d.inhib    = arg[LED_W-1];
                OP_LED:    st_d.led      = arg;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_reset    = st_q.p_reset;
    assign ctl_reconfig = st_q.p_reconf;
    assign ctl_zero     = st_q.p_zero;
    assign ctl_clear    = st_q.p_clear;
    assign test_mode    = st_q.test;
    assign inhibit      = st_q.inhib;
    assign led          = st_q.led;
endmodule

// File: rtl/crate_cycle_ctl.sv
module crate_cycle_ctl
    import crate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    input  logic               seq_done,
    input  logic [RD_W-1:0]    seq_rdata,
    input  logic               seq_q,
    input  logic               seq_x,
    output logic               seq_start,
    output logic [4:0]         seq_n,
    output logic [4:0]         seq_f,
    output logic [3:0]         seq_a,
    output logic [RD_W-1:0]    seq_w,
    output logic [HOST_DW-1:0] data_lat,
    output logic [HOST_AW-1:0] addr_lat,
    output logic               busy,
    output logic               done,
    output logic [RD_W-1:0]    rdat,
    output logic               rsp_q,
    output logic               rsp_x
);
    cyc_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (seq_done) begin
            st_d.rdat = seq_rdata;
            st_d.q    = seq_q;
            st_d.x    = seq_x;
            st_d.done = 1'b1;
            st_d.busy = 1'b0;
        end
        if (wr_en && !st_q.busy) begin
            st_d.data = host_wdata;
            st_d.addr = host_addr;
            if (host_addr[2]) begin
                st_d.start = 1'b1;
                st_d.busy  = 1'b1;
                st_d.done  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seq_start = st_q.start;
    assign seq_n     = st_q.addr[8:4];
    assign seq_f     = {st_q.addr[3], st_q.data[31:28]};
    assign seq_a     = st_q.data[27:24];
    assign seq_w     = st_q.data[RD_W-1:0];
    assign data_lat  = st_q.data;
    assign addr_lat  = st_q.addr;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign rdat      = st_q.rdat;
    assign rsp_q     = st_q.q;
    assign rsp_x     = st_q.x;
endmodule

// File: rtl/crate_cmd_regs.sv
module crate_cmd_regs
    import crate_pkg::*;
#(
    parameter logic [31:0] REVISION = 32'h2401_0A11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        seq_start,
    output logic [4:0]  seq_n,
    output logic [4:0]  seq_f,
    output logic [3:0]  seq_a,
    output logic [23:0] seq_w,
    input  logic        seq_done,
    input  logic [23:0] seq_rdata,
    input  logic        seq_q,
    input  logic        seq_x,
    input  logic        seq_busy_out,
    output logic        ctl_reset,
    output logic        ctl_reconfig,
    output logic        ctl_zero,
    output logic        ctl_clear,
    output logic        test_mode,
    output logic        inhibit,
    output logic [15:0] led
);
    logic [3:0]         idx;
    logic [NREG-1:0]    wr_sel;
    logic [HOST_DW-1:0] scratch_d, scratch_q;
    logic [HOST_DW-1:0] data_lat;
    logic [HOST_AW-1:0] addr_lat;
    logic               busy, done, rsp_q, rsp_x;
    logic [RD_W-1:0]    rdat;
    logic [HOST_DW-1:0] status_word;

    crate_addr_decode u_dec (
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .idx       (idx),
        .wr_sel    (wr_sel)
    );

    crate_cmd_unit u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_sel[IDX_CMD]),
        .code         (host_wdata[3:0]),
        .arg          (host_wdata[HOST_DW-1 -: LED_W]),
        .ctl_reset    (ctl_reset),
        .ctl_reconfig (ctl_reconfig),
        .ctl_zero     (ctl_zero),
        .ctl_clear    (ctl_clear),
        .test_mode    (test_mode),
        .inhibit      (inhibit),
        .led          (led)
    );

    crate_cycle_ctl u_cyc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_sel[IDX_CYC]),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .seq_done   (seq_done),
        .seq_rdata  (seq_rdata),
        .seq_q      (seq_q),
        .seq_x      (seq_x),
        .seq_start  (seq_start),
        .seq_n      (seq_n),
        .seq_f      (seq_f),
        .seq_a      (seq_a),
        .seq_w      (seq_w),
        .data_lat   (data_lat),
        .addr_lat   (addr_lat),
        .busy       (busy),
        .done       (done),
        .rdat       (rdat),
        .rsp_q      (rsp_q),
        .rsp_x      (rsp_x)
    );

    always_comb begin
        scratch_d = scratch_q;
        if (wr_sel[IDX_SCR]) scratch_d = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scratch_q <= '0;
        else        scratch_q <= scratch_d;
    end

    assign status_word = {3'b000, seq_busy_out, busy, done, rsp_x, rsp_q, rdat};

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (idx)
                IDX_REV:  host_rdata = REVISION;
                IDX_SCR:  host_rdata = scratch_q;
                IDX_CYC:  host_rdata = data_lat;
                IDX_ADR:  host_rdata = {{(HOST_DW-HOST_AW){1'b0}}, addr_lat};
                IDX_STAT: host_rdata = status_word;
                default:  host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/crate_cmd_regs_chk.sv
module crate_cmd_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [15:0] host_addr,
    input logic [31:0] host_wdata,
    input logic        seq_start,
    input logic [4:0]  seq_n,
    input logic [4:0]  seq_f,
    input logic [3:0]  seq_a,
    input logic [23:0] seq_w,
    input logic        seq_done,
    input logic [23:0] seq_rdata,
    input logic        seq_q,
    input logic        seq_x,
    input logic        busy,
    input logic [31:0] status_word,
    input logic [15:0] led
);
    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    p_busy_with_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);

    p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_start) |-> $stable({seq_n, seq_f, seq_a, seq_w}));

    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_addr[15:12] == 4'd4) |=> !seq_start);

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && busy) |=> (status_word[23:0] == $past(seq_rdata)
                                && status_word[24] == $past(seq_q)
                                && status_word[25] == $past(seq_x)
                                && status_word[26] && !status_word[27]));

    p_led_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr[15:12] == 4'd1 && host_wdata[3:0] == 4'd7) |=> $stable(led));
endmodule

bind crate_cmd_regs crate_cmd_regs_chk u_chk (.*);

// File: tb/crate_cmd_regs_tb.sv
module crate_cmd_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] REV = 32'h2401_0A11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        seq_start;
    logic [4:0]  seq_n, seq_f;
    logic [3:0]  seq_a;
    logic [23:0] seq_w;
    logic        seq_done = 1'b0;
    logic [23:0] seq_rdata = '0;
    logic        seq_q = 1'b0, seq_x = 1'b0, seq_busy_out = 1'b0;
    logic        ctl_reset, ctl_reconfig, ctl_zero, ctl_clear, test_mode, inhibit;
    logic [15:0] led;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crate_cmd_regs #(.REVISION(REV)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic finish_cycle(input logic [23:0] r, input logic q, input logic x);
        @(negedge clk);
        seq_done = 1'b1; seq_rdata = r; seq_q = q; seq_x = x;
        @(negedge clk);
        seq_done = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R8 led reset", 32'(led), 0);
        chk("R10 levels reset", {30'd0, test_mode, inhibit}, 0);
        chk("R4 no start at reset", 32'(seq_start), 0);
        rd(16'h6000, v); chk("R5 status reset", v, 0);
        rd(16'h2000, v); chk("R2 scratch reset", v, 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        rd(16'h0000, v); chk("R1 revision", v, REV);
        rd(16'h1000, v); chk("R1 command reads zero", v, 0);
        rd(16'h3000, v); chk("R1 index 3 zero", v, 0);
        rd(16'hF000, v); chk("R1 index 15 zero", v, 0);
        host_addr = 16'h0000; #1 chk("R1 no rd zero", host_rdata, 0);
    endtask

    task automatic t_scratch;
        logic [31:0] v;
        wr(16'h2000, 32'hDEAD_BEEF); rd(16'h2000, v); chk("R2 scratch a", v, 32'hDEAD_BEEF);
        wr(16'h2000, 32'h1234_5678); rd(16'h2000, v); chk("R2 scratch b", v, 32'h1234_5678);
    endtask

    task automatic t_latch_nostart;
        logic [31:0] v;
        wr(16'h4E58, 32'hA7AB_CDEF);
        chk("R4 no start when flag clear", 32'(seq_start), 0);
        chk("R3 N", 32'(seq_n), 32'd5);
        chk("R3 F", 32'(seq_f), 32'h1A);
        chk("R3 A", 32'(seq_a), 32'h7);
        chk("R3 W", 32'(seq_w), 32'hAB_CDEF);
        rd(16'h4000, v); chk("R3 data readback", v, 32'hA7AB_CDEF);
        rd(16'h5000, v); chk("R3 addr readback", v, 32'h0000_4E58);
        rd(16'h6000, v); chk("R5 not busy", 32'(v[27]), 0);
    endtask

    task automatic t_start_and_busy;
        logic [31:0] v;
        wr(16'h4174, 32'h0012_3456);
        chk("R4 start pulse", 32'(seq_start), 1);
        chk("R3 N slot 23", 32'(seq_n), 32'd23);
        chk("R3 F zero", 32'(seq_f), 0);
        chk("R3 W", 32'(seq_w), 32'h12_3456);
        rd(16'h6000, v); chk("R5 busy set", 32'(v[27:26]), 32'b10);
        @(negedge clk);
        chk("R4 one cycle pulse", 32'(seq_start), 0);
        wr(16'h416C, 32'h5300_0001);
        chk("R7 no start while busy", 32'(seq_start), 0);
        chk("R7 N held", 32'(seq_n), 32'd23);
        chk("R7 W held", 32'(seq_w), 32'h12_3456);
        rd(16'h4000, v); chk("R7 data readback held", v, 32'h0012_3456);
        rd(16'h5000, v); chk("R7 addr readback held", v, 32'h0000_4174);
        finish_cycle(24'hC0FFEE, 1'b1, 1'b0);
        rd(16'h6000, v);
        chk("R6 rdata", 32'(v[23:0]), 32'hC0FFEE);
        chk("R6 Q", 32'(v[24]), 1);
        chk("R6 X", 32'(v[25]), 0);
        chk("R5 done set busy clear", 32'(v[27:26]), 32'b01);
        chk("R6 upper zero", 32'(v[31:28]), 0);
        seq_busy_out = 1'b1;
        rd(16'h6000, v); chk("R6 busy_out mirror", 32'(v[28]), 1);
        seq_busy_out = 1'b0;
        wr(16'h4AAC, 32'hF900_0002);
        chk("R4 restart", 32'(seq_start), 1);
        chk("R3 F with top bit", 32'(seq_f), 32'h1F);
        chk("R3 N ignores 11..9", 32'(seq_n), 32'd10);
        chk("R3 A", 32'(seq_a), 32'h9);
        rd(16'h6000, v); chk("R5 done cleared on start", 32'(v[27:26]), 32'b10);
        finish_cycle(24'h000001, 1'b0, 1'b1);
        rd(16'h6000, v); chk("R6 second capture", v, 32'h0600_0001);
    endtask

    task automatic t_commands;
        logic [31:0] v;
        wr(16'h1000, 32'h01F8_0007); chk("R8 led load", 32'(led), 32'h01F8);
        wr(16'h1000, 32'hFFFF_0005); chk("R8 led unchanged by clear", 32'(led), 32'h01F8);
        chk("R9 clear pulse", {28'd0, ctl_reset, ctl_reconfig, ctl_zero, ctl_clear}, 32'b0001);
        @(negedge clk);
        chk("R9 clear pulse ends", 32'(ctl_clear), 0);
        wr(16'h1000, 32'h0000_0001);
        chk("R9 reset pulse", {28'd0, ctl_reset, ctl_reconfig, ctl_zero, ctl_clear}, 32'b1000);
        wr(16'h1000, 32'h0000_0002);
        chk("R9 reconfig pulse", {28'd0, ctl_reset, ctl_reconfig, ctl_zero, ctl_clear}, 32'b0100);
        wr(16'h1000, 32'h0000_0004);
        chk("R9 zero pulse", {28'd0, ctl_reset, ctl_reconfig, ctl_zero, ctl_clear}, 32'b0010);
        wr(16'h1000, 32'h8000_0003); chk("R10 test mode on", 32'(test_mode), 1);
        wr(16'h1000, 32'h8000_0006); chk("R10 inhibit on", 32'(inhibit), 1);
        wr(16'h1000, 32'h0000_0003); chk("R10 test mode off", {30'd0, test_mode, inhibit}, 32'b01);
        wr(16'h2000, 32'hABCD_0007); chk("R8 scratch write leaves led", 32'(led), 32'h01F8);
        rd(16'h1000, v); chk("R1 command still reads zero", v, 0);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        wr(16'h0000, 32'h5555_5555); rd(16'h0000, v); chk("R11 revision unchanged", v, REV);
        wr(16'h6000, 32'hFFFF_FFFF); rd(16'h6000, v); chk("R11 status unchanged", v, 32'h0600_0001);
        chk("R11 no start from status write", 32'(seq_start), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_map;
        t_scratch;
        t_latch_nostart;
        t_start_and_busy;
        t_commands;
        t_readonly;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule